// File: doc/BRIEF.md
# APB3 to AXI4 Narrow-Access Bridge

This block sits between a 32-bit APB3 requester and a 64-bit AXI4 register file. Each APB access is turned into exactly one single-beat AXI4 transaction of four bytes. Address bit 2 selects which half of the wide bus is used. On writes, the APB word is steered into that half of the write data and the matching four byte strobes are raised. On reads, the word is taken from that half of the returned data.

The APB side is stalled with PREADY low until the AXI response comes back. The response code is then turned into PSLVERR. Only one AXI transaction is ever in flight. The register file holds 64-bit registers spaced eight bytes apart, so software writes or reads a full register with two APB accesses: the low word at offset +0 and the high word at offset +4.

Top module: `apb_axi_narrow_bridge`

## Requirements
- R1: After the access phase is entered, PREADY is low in the first access cycle and in every cycle until the AXI response, so each transfer has at least one wait state. PREADY is then high for exactly one cycle.
- R2: Each APB access issues exactly one AXI transaction with length 0, size 3'b010, burst type INCR (2'b01) and ID 0. A read and a write are never presented at the same time.
- R3: On a write with PADDR[2]=0, WSTRB is 8'h0F, WDATA[31:0] carries PWDATA and WDATA[63:32] is zero. With PADDR[2]=1, WSTRB is 8'hF0, WDATA[63:32] carries PWDATA and WDATA[31:0] is zero. WLAST is 1.
- R4: AWADDR and ARADDR equal PADDR unchanged. Each valid stays high, with its payload stable, until its ready is seen.
- R5: On a read, PRDATA is RDATA[63:32] when PADDR[2]=1 and RDATA[31:0] otherwise.
- R6: PSLVERR is 1 when bit 1 of the response is set (SLVERR 2'b10, DECERR 2'b11) and 0 for OKAY 2'b00 and EXOKAY 2'b01. This holds for both BRESP and RRESP.
- R7: The write address and write data handshakes may complete in the same cycle or in either order. Each channel is presented exactly once per write.
- R8: While reset is low, AWVALID, WVALID, ARVALID, PREADY, PSLVERR and PRDATA are all 0.
- R9: BREADY and RREADY are held high at all times.
- R10: APB transfers issued back to back, each new setup phase in the cycle right after the previous completion, are each carried out correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| paddr | input | ADDR_W | APB byte address |
| pwrite | input | 1 | APB write when 1 |
| pwdata | input | APB_DW | APB write data |
| prdata | output | APB_DW | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| awid | output | 1 | Write ID (0) |
| awlen | output | 8 | Burst length (0) |
| awsize | output | 3 | Beat size |
| awburst | output | 2 | Burst type (INCR) |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | AXI_DW | Write data |
| wstrb | output | AXI_DW/8 | Byte strobes |
| wlast | output | 1 | Last beat (1) |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready (1) |
| bresp | input | 2 | Write response |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Read address |
| arid | output | 1 | Read ID (0) |
| arlen | output | 8 | Burst length (0) |
| arsize | output | 3 | Beat size |
| arburst | output | 2 | Burst type (INCR) |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready (1) |
| rdata | input | AXI_DW | Read data |
| rresp | input | 2 | Read response |

## Verification
Two events can land on the same clock edge: the write address handshake and the write data handshake. The bench provokes this by raising AWREADY and WREADY together. It also runs the two orderings, with one ready held back by three cycles, and a run with random latencies.

Each case is judged on the handshake counts, which must show exactly one AW beat and one W beat per transfer. It is also judged on the captured strobe and data placement, and on a single one-cycle PREADY pulse returned only after BVALID.

// File: rtl/apb_axi_bridge_pkg.sv
package apb_axi_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AW_W,
    ST_W,
    ST_B,
    ST_AR,
    ST_R
  } bridgeState_t;

  typedef struct packed {
    logic capture;
    logic takeWrResp;
    logic takeRdResp;
  } ctrlStrobe_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/apb_axi_bridge_ctrl.sv
module apb_axi_bridge_ctrl
  import apb_axi_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic        awready,
  input  logic        wready,
  input  logic        bvalid,
  input  logic        arready,
  input  logic        rvalid,
  output logic        pready,
  output logic        awvalid,
  output logic        wvalid,
  output logic        arvalid,
  output ctrlStrobe_t strobe
);

  bridgeState_t stateQ, stateD;
  logic wDoneQ, wDoneD;
  logic readyQ;
  logic start, awHs, wHs, wrDone, rdDone;

  // A new access starts only in IDLE, and not in the cycle that completes the previous one.
  assign start  = (stateQ == ST_IDLE) && psel && penable && !readyQ;
  assign awHs   = awvalid && awready;
  assign wHs    = wvalid && wready;
  assign wrDone = (stateQ == ST_B) && bvalid;
  assign rdDone = (stateQ == ST_R) && rvalid;

  always_comb begin
    stateD = stateQ;
    wDoneD = wDoneQ;
    unique case (stateQ)
      ST_IDLE: begin
        wDoneD = 1'b0;
        if (start) stateD = pwrite ? ST_AW_W : ST_AR;
      end
      ST_AW_W: begin
        if (awHs)     stateD = (wDoneQ || wHs) ? ST_B : ST_W;
        else if (wHs) wDoneD = 1'b1;
      end
      ST_W:    if (wHs)     stateD = ST_B;
      ST_B:    if (bvalid)  stateD = ST_IDLE;
      ST_AR:   if (arready) stateD = ST_R;
      ST_R:    if (rvalid)  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      wDoneQ <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      wDoneQ <= wDoneD;
      readyQ <= wrDone || rdDone;
    end
  end

  assign awvalid = (stateQ == ST_AW_W);
  assign wvalid  = ((stateQ == ST_AW_W) && !wDoneQ) || (stateQ == ST_W);
  assign arvalid = (stateQ == ST_AR);
  assign pready  = readyQ;

  assign strobe.capture    = start;
  assign strobe.takeWrResp = wrDone;
  assign strobe.takeRdResp = rdDone;

endmodule

// File: rtl/apb_axi_bridge_dpath.sv
module apb_axi_bridge_dpath
  import apb_axi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int APB_DW = 32,
  parameter int AXI_DW = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [APB_DW-1:0]     pwdata,
  input  logic [1:0]            bresp,
  input  logic [1:0]            rresp,
  input  logic [AXI_DW-1:0]     rdata,
  output logic [ADDR_W-1:0]     axAddr,
  output logic [AXI_DW-1:0]     wdata,
  output logic [AXI_DW/8-1:0]   wstrb,
  output logic [APB_DW-1:0]     prdata,
  output logic                  pslverr
);

  localparam int LANES     = AXI_DW / APB_DW;
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LANE_LSB  = $clog2(APB_DW / 8);
  localparam int LANE_STRB = APB_DW / 8;

  logic [ADDR_W-1:0]    addrQ;
  logic [APB_DW-1:0]    dataQ;
  logic [LANE_BITS-1:0] laneSel;
  logic [APB_DW-1:0]    rdLanes [LANES];

  assign laneSel = addrQ[LANE_LSB +: LANE_BITS];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[g*APB_DW +: APB_DW]       = (laneSel == LANE_BITS'(g)) ? dataQ : '0;
    assign wstrb[g*LANE_STRB +: LANE_STRB] = (laneSel == LANE_BITS'(g)) ? '1 : '0;
    assign rdLanes[g]                      = rdata[g*APB_DW +: APB_DW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      prdata  <= '0;
      pslverr <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrQ <= paddr;
        dataQ <= pwdata;
      end
      // Bit 1 of the response marks both error codes.
      if (strobe.takeWrResp) pslverr <= bresp[1];
      if (strobe.takeRdResp) begin
        pslverr <= rresp[1];
        prdata  <= rdLanes[laneSel];
      end
    end
  end

  assign axAddr = addrQ;

endmodule

// File: rtl/apb_axi_narrow_bridge.sv
module apb_axi_narrow_bridge
  import apb_axi_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int APB_DW = 32,
  parameter int AXI_DW = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic                pwrite,
  input  logic [APB_DW-1:0]   pwdata,
  output logic [APB_DW-1:0]   prdata,
  output logic                pready,
  output logic                pslverr,
  output logic                awvalid,
  input  logic                awready,
  output logic [ADDR_W-1:0]   awaddr,
  output logic                awid,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                wvalid,
  input  logic                wready,
  output logic [AXI_DW-1:0]   wdata,
  output logic [AXI_DW/8-1:0] wstrb,
  output logic                wlast,
  input  logic                bvalid,
  output logic                bready,
  input  logic [1:0]          bresp,
  output logic                arvalid,
  input  logic                arready,
  output logic [ADDR_W-1:0]   araddr,
  output logic                arid,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic [1:0]          arburst,
  input  logic                rvalid,
  output logic                rready,
  input  logic [AXI_DW-1:0]   rdata,
  input  logic [1:0]          rresp
);

  localparam logic [2:0] BEAT_SIZE = 3'($clog2(APB_DW / 8));

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] axAddr;

  apb_axi_bridge_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .awready (awready),
    .wready  (wready),
    .bvalid  (bvalid),
    .arready (arready),
    .rvalid  (rvalid),
    .pready  (pready),
    .awvalid (awvalid),
    .wvalid  (wvalid),
    .arvalid (arvalid),
    .strobe  (strobe)
  );

  apb_axi_bridge_dpath #(
    .ADDR_W (ADDR_W),
    .APB_DW (APB_DW),
    .AXI_DW (AXI_DW)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .bresp   (bresp),
    .rresp   (rresp),
    .rdata   (rdata),
    .axAddr  (axAddr),
    .wdata   (wdata),
    .wstrb   (wstrb),
    .prdata  (prdata),
    .pslverr (pslverr)
  );

  assign awaddr  = axAddr;
  assign araddr  = axAddr;
  assign awid    = 1'b0;
  assign arid    = 1'b0;
  assign awlen   = 8'd0;
  assign arlen   = 8'd0;
  assign awsize  = BEAT_SIZE;
  assign arsize  = BEAT_SIZE;
  assign awburst = BURST_INCR;
  assign arburst = BURST_INCR;
  assign wlast   = 1'b1;
  assign bready  = 1'b1;
  assign rready  = 1'b1;

endmodule

// File: rtl/apb_axi_narrow_bridge_chk.sv
module apb_axi_narrow_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int APB_DW = 32,
  parameter int AXI_DW = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                psel,
  input logic                penable,
  input logic                pready,
  input logic                awvalid,
  input logic                awready,
  input logic [ADDR_W-1:0]   awaddr,
  input logic                wvalid,
  input logic                wready,
  input logic [AXI_DW-1:0]   wdata,
  input logic [AXI_DW/8-1:0] wstrb,
  input logic                arvalid,
  input logic                arready,
  input logic [ADDR_W-1:0]   araddr,
  input logic                bready,
  input logic                rready
);

  AST_PREADY_PULSE: assert property (@(posedge clk) disable iff (!rstN) pready |=> !pready); // R1
  AST_PREADY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN) pready |-> (psel && penable)); // R1
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN) !((awvalid || wvalid) && arvalid)); // R2
  AST_STRB_HALF: assert property (@(posedge clk) disable iff (!rstN) wvalid |-> ($countones(wstrb) == APB_DW/8)); // R3
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rstN) (awvalid && !awready) |=> (awvalid && $stable(awaddr))); // R4
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rstN) (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb))); // R4
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rstN) (arvalid && !arready) |=> (arvalid && $stable(araddr))); // R4
  AST_AW_ONCE: assert property (@(posedge clk) disable iff (!rstN) (awvalid && awready) |=> !awvalid); // R7
  AST_W_ONCE: assert property (@(posedge clk) disable iff (!rstN) (wvalid && wready) |=> !wvalid); // R7
  AST_RESP_READY: assert property (@(posedge clk) disable iff (!rstN) (bready && rready)); // R9

endmodule

bind apb_axi_narrow_bridge apb_axi_narrow_bridge_chk #(
  .ADDR_W (ADDR_W),
  .APB_DW (APB_DW),
  .AXI_DW (AXI_DW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .psel    (psel),
  .penable (penable),
  .pready  (pready),
  .awvalid (awvalid),
  .awready (awready),
  .awaddr  (awaddr),
  .wvalid  (wvalid),
  .wready  (wready),
  .wdata   (wdata),
  .wstrb   (wstrb),
  .arvalid (arvalid),
  .arready (arready),
  .araddr  (araddr),
  .bready  (bready),
  .rready  (rready)
);

// File: tb/apb_axi_narrow_bridge_tb_top.sv
`timescale 1ns/1ps
module apb_axi_narrow_bridge_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        psel = 0, penable = 0, pwrite = 0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        awvalid, awid, wvalid, wlast, bready, arvalid, arid, rready;
  logic        awready = 0, wready = 0, arready = 0, bvalid = 0, rvalid = 0;
  logic [15:0] awaddr, araddr;
  logic [7:0]  awlen, arlen, wstrb;
  logic [2:0]  awsize, arsize;
  logic [1:0]  awburst, arburst;
  logic [63:0] wdata;
  logic [1:0]  bresp = 0, rresp = 0;
  logic [63:0] rdata = '0;

  apb_axi_narrow_bridge dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .paddr(paddr),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .awid(awid), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .wlast(wlast), .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arid(arid),
    .arlen(arlen), .arsize(arsize), .arburst(arburst), .rvalid(rvalid),
    .rready(rready), .rdata(rdata), .rresp(rresp)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // AXI responder: readies decided at the negedge for the following posedge
  int awDly = 0, wDly = 0, bDly = 0, arDly = 0, rDly = 0;
  int awWait = 0, wWait = 0, bWait = 0, arWait = 0, rWait = 0;
  int awCnt = 0, wCnt = 0, arCnt = 0;
  bit bSent = 0, rSent = 0;
  logic [1:0]  bRespNext = 0, rRespNext = 0;
  logic [63:0] rDataNext = '0;
  logic [15:0] capAwAddr, capArAddr;
  logic [7:0]  capAwLen, capArLen, capWStrb;
  logic [2:0]  capAwSize, capArSize;
  logic [1:0]  capAwBurst, capArBurst;
  logic        capAwId, capArId, capWLast;
  logic [63:0] capWData;

  always @(negedge clk) begin
    if (rstN) begin
      awready = 0;
      if (awvalid) begin
        if (awWait >= awDly) begin
          awready = 1; awCnt++; awWait = 0;
          capAwAddr = awaddr; capAwLen = awlen; capAwSize = awsize;
          capAwBurst = awburst; capAwId = awid;
        end else awWait++;
      end
      wready = 0;
      if (wvalid) begin
        if (wWait >= wDly) begin
          wready = 1; wCnt++; wWait = 0;
          capWData = wdata; capWStrb = wstrb; capWLast = wlast;
        end else wWait++;
      end
      arready = 0;
      if (arvalid) begin
        if (arWait >= arDly) begin
          arready = 1; arCnt++; arWait = 0;
          capArAddr = araddr; capArLen = arlen; capArSize = arsize;
          capArBurst = arburst; capArId = arid;
        end else arWait++;
      end
      bvalid = 0;
      if (awCnt == 1 && wCnt == 1 && !bSent && !awvalid && !wvalid) begin
        if (bWait >= bDly) begin bvalid = 1; bresp = bRespNext; bSent = 1; end
        else bWait++;
      end
      rvalid = 0;
      if (arCnt == 1 && !rSent && !arvalid) begin
        if (rWait >= rDly) begin rvalid = 1; rdata = rDataNext; rresp = rRespNext; rSent = 1; end
        else rWait++;
      end
    end
  end

  task automatic arm(input int mode);
    awCnt = 0; wCnt = 0; arCnt = 0; bSent = 0; rSent = 0;
    awWait = 0; wWait = 0; bWait = 0; arWait = 0; rWait = 0;
    case (mode)
      0: begin awDly = 0; wDly = 0; end
      1: begin awDly = 0; wDly = 3; end
      2: begin awDly = 3; wDly = 0; end
      default: begin awDly = $urandom_range(0, 3); wDly = $urandom_range(0, 3); end
    endcase
    arDly = $urandom_range(0, 3); bDly = $urandom_range(0, 3); rDly = $urandom_range(0, 3);
  endtask

  // Called at a negedge; returns at the negedge after completion with psel still high
  task automatic apbXfer(input bit wr, input logic [15:0] addr, input logic [31:0] data,
                         output logic [31:0] rd, output logic err, output int waits, output bit firstLow);
    psel = 1; penable = 0; pwrite = wr; paddr = addr; pwdata = data;
    @(negedge clk);
    penable = 1;
    #1;
    firstLow = !pready;
    waits = 0;
    while (!pready) begin
      @(negedge clk); #1;
      if (!pready) waits++;
    end
    rd = prdata; err = pslverr;
    waits++;
    @(negedge clk);
    penable = 0;
    #1;
    check(!pready, "R1 pready single cycle", 64'(pready), 64'd0);
  endtask

  task automatic idle();
    psel = 0; penable = 0;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [15:0] addr, input logic [31:0] data, input int mode, input logic [1:0] resp);
    logic [31:0] rd; logic err; int waits; bit firstLow;
    logic [63:0] expData;
    arm(mode); bRespNext = resp;
    apbXfer(1, addr, data, rd, err, waits, firstLow);
    expData = addr[2] ? {data, 32'h0} : {32'h0, data};
    check(firstLow, "R1 pready low in first access cycle", 64'(!firstLow), 64'd0);
    check(awCnt == 1 && wCnt == 1 && arCnt == 0, "R7 one AW and one W beat", 64'(awCnt*16 + wCnt), 64'h11);
    check(capAwAddr == addr, "R4 awaddr", 64'(capAwAddr), 64'(addr));
    check(capAwLen == 0 && capAwSize == 3'b010 && capAwBurst == 2'b01 && capAwId == 0,
          "R2 aw attributes", {capAwLen, 5'd0, capAwSize, 6'd0, capAwBurst, 3'd0, capAwId},
          {8'd0, 5'd0, 3'b010, 6'd0, 2'b01, 3'd0, 1'b0});
    check(capWStrb == (addr[2] ? 8'hF0 : 8'h0F), "R3 wstrb", 64'(capWStrb), 64'(addr[2] ? 8'hF0 : 8'h0F));
    check(capWData == expData, "R3 wdata placement", capWData, expData);
    check(capWLast == 1, "R3 wlast", 64'(capWLast), 64'd1);
    check(err == resp[1], "R6 bresp to pslverr", 64'(err), 64'(resp[1]));
  endtask

  task automatic doRead(input logic [15:0] addr, input logic [63:0] word, input logic [1:0] resp);
    logic [31:0] rd; logic err; int waits; bit firstLow;
    logic [31:0] expRd;
    arm(3); rDataNext = word; rRespNext = resp;
    apbXfer(0, addr, 32'h0, rd, err, waits, firstLow);
    expRd = addr[2] ? word[63:32] : word[31:0];
    check(firstLow && waits >= 1, "R1 read wait state", 64'(waits), 64'd1);
    check(arCnt == 1 && awCnt == 0 && wCnt == 0, "R2 one AR only", 64'(arCnt), 64'd1);
    check(capArAddr == addr, "R4 araddr", 64'(capArAddr), 64'(addr));
    check(capArLen == 0 && capArSize == 3'b010 && capArBurst == 2'b01 && capArId == 0,
          "R2 ar attributes", 64'({capArLen, capArSize, capArBurst, capArId}), 64'({8'd0, 3'b010, 2'b01, 1'b0}));
    check(rd == expRd, "R5 read half select", 64'(rd), 64'(expRd));
    check(err == resp[1], "R6 rresp to pslverr", 64'(err), 64'(resp[1]));
  endtask

  task automatic testReset();
    check(!awvalid && !wvalid && !arvalid, "R8 valids low in reset", 64'({awvalid, wvalid, arvalid}), 64'd0);
    check(!pready && !pslverr && prdata == 0, "R8 apb outputs low in reset", 64'({pready, pslverr}), 64'd0);
    check(bready && rready, "R9 response readies high", 64'({bready, rready}), 64'h3);
  endtask

  task automatic testWriteOrders();
    doWrite(16'h19F0, 32'hDEADBEEF, 0, 2'b00); idle();   // R7 same-cycle handshakes
    doWrite(16'h19F4, 32'hCAFEF00D, 0, 2'b00); idle();
    doWrite(16'h1000, 32'h12345678, 1, 2'b00); idle();   // R7 AW before W
    doWrite(16'h1004, 32'h9ABCDEF0, 2, 2'b00); idle();   // R7 W before AW
  endtask

  task automatic testErrors();
    doWrite(16'h2008, 32'h0BADC0DE, 3, 2'b10); idle();   // R6 SLVERR
    doWrite(16'h200C, 32'h00C0FFEE, 3, 2'b11); idle();   // R6 DECERR
    doWrite(16'h2010, 32'h55AA55AA, 3, 2'b01); idle();   // R6 EXOKAY
    doRead(16'h2000, 64'h1111_2222_3333_4444, 2'b10); idle();
    doRead(16'h2004, 64'h5555_6666_7777_8888, 2'b00); idle();
  endtask

  task automatic testReads();
    doRead(16'h19F0, 64'hA5A5_0001_CAFE_BABE, 2'b00); idle(); // R5 low half
    doRead(16'h19F4, 64'hA5A5_0001_CAFE_BABE, 2'b00); idle(); // R5 high half
  endtask

  task automatic testBackToBack();
    for (int i = 0; i < 12; i++) begin
      logic [15:0] a = 16'h3000 + 16'(i * 4);
      if (i % 3 == 2) doRead(a, {32'hF0F0_0000 + 32'(i), 32'h0F0F_0000 + 32'(i)}, 2'b00); // R10
      else doWrite(a, 32'hB2B0_0000 + 32'(i), 3, 2'(i % 4 == 1 ? 2 : 0));               // R10
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testWriteOrders();
    testReads();
    testErrors();
    testBackToBack();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule